// File: doc/BRIEF.md
# Power-On Sequencing Controller

This block takes a system from battery attach to run mode. It watches two asynchronous inputs: a battery-fault line and an external reset line. Once a clean reset release is seen, it raises the system-rail enable and then the core-rail enable, in that order. It waits a timed settling window, checks that the rails report good, and only then releases the reset that holds the processor core.

Every interval is counted in periods of a slow reference tick, nominally one millisecond. The three intervals are parameters: the release-to-system-rail delay, the system-rail-to-core-rail delay, and the core-rail settling window. Simulation can therefore use short counts.

The supply-fault input is looked at in exactly one cycle, when the settling window ends. If it reports a problem, the controller drops both enables and parks in a fault state. A low battery-fault line or an asserted external reset returns the controller to idle from any state.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `sys_en_o`, `pwr_en_o` and `core_rst_n_o` are 0 and `state_o` reads 0 (IDLE).
- R2: `ext_rst_n_i`, `batt_fault_n_i` and `rail_fault_n_i` each pass through a two-flop synchronizer. A change on one of these pins reaches `state_o` on the third rising clock edge after it, and not before.
- R3: From IDLE (0), the controller moves to WAIT_SYS (1) only on a low-to-high transition of the synchronized external reset while the synchronized battery line is high. A battery line that returns high while the reset is already released does not start a sequence.
- R4: In WAIT_SYS, after `SYS_DLY_TICKS` counted ticks, the controller enters WAIT_PWR (2) and raises `sys_en_o`.
- R5: In WAIT_PWR, after `PWR_DLY_TICKS` counted ticks, the controller enters WAIT_RAIL (3) and raises `pwr_en_o`, with `sys_en_o` kept high.
- R6: The level of `rail_fault_n_i` has no effect while the `RAIL_DLY_TICKS` window of WAIT_RAIL is still running.
- R7: When the window ends, a synchronized rail-good level of 1 moves the controller to RUN (4) and raises `core_rst_n_o`, with both enables kept high.
- R8: When the window ends, a synchronized rail level of 0 moves the controller to FAULT (5) with all three outputs low. It stays there whatever the rail or tick inputs do, until the external reset is asserted.
- R9: A synchronized external reset that is low, or a synchronized battery line that is low, sends any state to IDLE on the next edge, with all three outputs low.
- R10: A tick counts only in a cycle where the state does not change; the count restarts at zero on every state change. `pwr_en_o` is never high without `sys_en_o`, and `core_rst_n_o` is never high without `pwr_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Block reset, asynchronous assert, active low |
| tick_i | input | 1 | One-cycle reference tick pulse, synchronous to `clk` |
| ext_rst_n_i | input | 1 | External reset request, active low, asynchronous |
| batt_fault_n_i | input | 1 | Battery fault, active low, asynchronous |
| rail_fault_n_i | input | 1 | Supply-good report, low means fault, asynchronous |
| sys_en_o | output | 1 | System-rail enable |
| pwr_en_o | output | 1 | Core-rail enable |
| core_rst_n_o | output | 1 | Reset to the processor core, active low |
| state_o | output | 3 | Sequencer state: 0 IDLE, 1 WAIT_SYS, 2 WAIT_PWR, 3 WAIT_RAIL, 4 RUN, 5 FAULT |

## Verification
A pin change takes two synchronizer edges and then one state edge to show up, so the bench checks a reset release or abort three edges after the drive, and checks just before that point that nothing has moved yet. A timer expiry shows one edge after the tick that completes the count. The bench samples on falling edges a few cycles after each counted tick. A reference model in the bench steps with the same edge count and is compared with every output on every falling edge, during directed and random phases alike.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PS_IDLE      = 3'd0,
    PS_WAIT_SYS  = 3'd1,
    PS_WAIT_PWR  = 3'd2,
    PS_WAIT_RAIL = 3'd3,
    PS_RUN       = 3'd4,
    PS_FAULT     = 3'd5
  } pseq_state_e;

  localparam int unsigned PS_STATE_W = 3;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end
    end

    assign q_o[b] = chain_q[LAST];
  end

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired_o = (cnt_q >= limit_i);

  always_comb begin
    cnt_en = clr_i | (tick_i & ~expired_o);
    cnt_d  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_i) else $error("count past limit"); // R4

  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)) else $error("count not restarted"); // R10

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CNT_W          = 7,
  parameter int unsigned SYS_DLY_TICKS  = 10,
  parameter int unsigned PWR_DLY_TICKS  = 125,
  parameter int unsigned RAIL_DLY_TICKS = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_ok_i,
  input  logic             batt_ok_i,
  input  logic             rail_ok_i,
  input  logic             expired_i,
  output logic             clr_o,
  output logic [CNT_W-1:0] limit_o,
  output pseq_state_e      state_o,
  output logic             sys_en_o,
  output logic             pwr_en_o,
  output logic             core_rst_n_o
);

  pseq_state_e state_q;
  pseq_state_e state_d;
  logic        ext_prev_q;
  logic        release_seen;
  logic        sys_en_q;
  logic        pwr_en_q;
  logic        core_rst_n_q;

  assign release_seen = ext_ok_i & ~ext_prev_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (!ext_ok_i || !batt_ok_i) begin
      state_d = PS_IDLE;
    end else begin
      unique case (state_q)
        PS_IDLE:      if (release_seen) state_d = PS_WAIT_SYS;
        PS_WAIT_SYS:  if (expired_i)    state_d = PS_WAIT_PWR;
        PS_WAIT_PWR:  if (expired_i)    state_d = PS_WAIT_RAIL;
        PS_WAIT_RAIL: if (expired_i)    state_d = rail_ok_i ? PS_RUN : PS_FAULT;
        PS_RUN:       state_d = PS_RUN;
        PS_FAULT:     state_d = PS_FAULT;
        default:      state_d = PS_IDLE;
      endcase
    end
  end

  // limit selection for the tick timer
  always_comb begin
    unique case (state_q)
      PS_WAIT_SYS:  limit_o = CNT_W'(SYS_DLY_TICKS);
      PS_WAIT_PWR:  limit_o = CNT_W'(PWR_DLY_TICKS);
      PS_WAIT_RAIL: limit_o = CNT_W'(RAIL_DLY_TICKS);
      default:      limit_o = '1;
    endcase
  end

  assign clr_o = (state_d != state_q);

  // state and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= PS_IDLE;
      ext_prev_q   <= 1'b0;
      sys_en_q     <= 1'b0;
      pwr_en_q     <= 1'b0;
      core_rst_n_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      ext_prev_q   <= ext_ok_i;
      sys_en_q     <= (state_d == PS_WAIT_PWR) || (state_d == PS_WAIT_RAIL) || (state_d == PS_RUN);
      pwr_en_q     <= (state_d == PS_WAIT_RAIL) || (state_d == PS_RUN);
      core_rst_n_q <= (state_d == PS_RUN);
    end
  end

  assign state_o      = state_q;
  assign sys_en_o     = sys_en_q;
  assign pwr_en_o     = pwr_en_q;
  assign core_rst_n_o = core_rst_n_q;

  AST_PWR_NEEDS_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en_q |-> sys_en_q) else $error("core rail without system rail"); // R10

  AST_RUN_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n_q |-> pwr_en_q) else $error("core released without rail"); // R10

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_ok_i || !batt_ok_i) |=> (state_q == PS_IDLE && !sys_en_q)) else $error("abort missed"); // R9

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_FAULT && ext_ok_i && batt_ok_i) |=> (state_q == PS_FAULT)) else $error("fault left"); // R8

  AST_START_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_IDLE && !(ext_ok_i && !ext_prev_q)) |=> (state_q == PS_IDLE)) else $error("start without release"); // R3

  AST_RAIL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_WAIT_RAIL && !expired_i) |=> (state_q == PS_WAIT_RAIL || state_q == PS_IDLE)) else $error("rail sampled early"); // R6

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned SYS_DLY_TICKS  = 10,
  parameter int unsigned PWR_DLY_TICKS  = 125,
  parameter int unsigned RAIL_DLY_TICKS = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ext_rst_n_i,
  input  logic       batt_fault_n_i,
  input  logic       rail_fault_n_i,
  output logic       sys_en_o,
  output logic       pwr_en_o,
  output logic       core_rst_n_o,
  output logic [2:0] state_o
);

  localparam int unsigned MAX_A  = (SYS_DLY_TICKS > PWR_DLY_TICKS) ? SYS_DLY_TICKS : PWR_DLY_TICKS;
  localparam int unsigned MAX_D  = (MAX_A > RAIL_DLY_TICKS) ? MAX_A : RAIL_DLY_TICKS;
  localparam int unsigned CNT_W  = $clog2(MAX_D + 2);
  localparam int unsigned N_ASYN = 3;

  logic [N_ASYN-1:0] raw_in;
  logic [N_ASYN-1:0] synced;
  logic              tmr_clr;
  logic              tmr_exp;
  logic [CNT_W-1:0]  tmr_limit;
  pseq_state_e       fsm_state;

  assign raw_in = {rail_fault_n_i, batt_fault_n_i, ext_rst_n_i};

  pwr_seq_sync #(
    .WIDTH  (N_ASYN),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (synced)
  );

  pwr_seq_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .tick_i    (tick_i),
    .limit_i   (tmr_limit),
    .expired_o (tmr_exp)
  );

  pwr_seq_fsm #(
    .CNT_W          (CNT_W),
    .SYS_DLY_TICKS  (SYS_DLY_TICKS),
    .PWR_DLY_TICKS  (PWR_DLY_TICKS),
    .RAIL_DLY_TICKS (RAIL_DLY_TICKS)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_ok_i     (synced[0]),
    .batt_ok_i    (synced[1]),
    .rail_ok_i    (synced[2]),
    .expired_i    (tmr_exp),
    .clr_o        (tmr_clr),
    .limit_o      (tmr_limit),
    .state_o      (fsm_state),
    .sys_en_o     (sys_en_o),
    .pwr_en_o     (pwr_en_o),
    .core_rst_n_o (core_rst_n_o)
  );

  assign state_o = fsm_state;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!sys_en_o && !pwr_en_o && !core_rst_n_o)) else $error("outputs live in reset"); // R1

endmodule

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;

  localparam int SYS_D  = 3;
  localparam int PWR_D  = 5;
  localparam int RAIL_D = 4;
  localparam logic [2:0] S_IDLE = 3'd0, S_WSYS = 3'd1, S_WPWR = 3'd2,
                         S_WRAIL = 3'd3, S_RUN = 3'd4, S_FAULT = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n, tick, ext_n, batt_n, rail_n;
  logic       sys_en, pwr_en, core_rst_n;
  logic [2:0] state;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(
    .SYNC_STAGES    (2),
    .SYS_DLY_TICKS  (SYS_D),
    .PWR_DLY_TICKS  (PWR_D),
    .RAIL_DLY_TICKS (RAIL_D)
  ) i_pwr_seq_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_i         (tick),
    .ext_rst_n_i    (ext_n),
    .batt_fault_n_i (batt_n),
    .rail_fault_n_i (rail_n),
    .sys_en_o       (sys_en),
    .pwr_en_o       (pwr_en),
    .core_rst_n_o   (core_rst_n),
    .state_o        (state)
  );

  // reference model built from the requirements
  logic [1:0] m_e, m_b, m_r;
  logic       m_prev;
  logic [2:0] m_st;
  int         m_cnt;
  logic       m_sys, m_pwr, m_crn;

  function automatic int lim_of(logic [2:0] s);
    case (s)
      S_WSYS:  return SYS_D;
      S_WPWR:  return PWR_D;
      S_WRAIL: return RAIL_D;
      default: return 1 << 30;
    endcase
  endfunction

  function automatic logic [2:0] nxt_of(logic [2:0] s, logic e, logic b, logic r,
                                        logic prev, logic exp);
    if (!e || !b) return S_IDLE;
    case (s)
      S_IDLE:  return (e && !prev) ? S_WSYS : S_IDLE;
      S_WSYS:  return exp ? S_WPWR : S_WSYS;
      S_WPWR:  return exp ? S_WRAIL : S_WPWR;
      S_WRAIL: return exp ? (r ? S_RUN : S_FAULT) : S_WRAIL;
      default: return s;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] s);
    case (s)
      S_IDLE:  return "R9";
      S_WSYS:  return "R3";
      S_WPWR:  return "R4";
      S_WRAIL: return "R5";
      S_RUN:   return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_e = '0; m_b = '0; m_r = '0; m_prev = 0; m_st = S_IDLE; m_cnt = 0;
      m_sys = 0; m_pwr = 0; m_crn = 0;
    end else begin
      logic [2:0] nx;
      logic       ex;
      ex = (m_cnt >= lim_of(m_st));
      nx = nxt_of(m_st, m_e[1], m_b[1], m_r[1], m_prev, ex);
      if (nx != m_st) m_cnt = 0;
      else if (tick && !ex) m_cnt = m_cnt + 1;
      m_prev = m_e[1];
      m_st   = nx;
      m_sys  = (nx == S_WPWR) || (nx == S_WRAIL) || (nx == S_RUN);
      m_pwr  = (nx == S_WRAIL) || (nx == S_RUN);
      m_crn  = (nx == S_RUN);
      m_e = {m_e[0], ext_n};
      m_b = {m_b[0], batt_n};
      m_r = {m_r[0], rail_n};
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, plus ordering (R10)
  always @(negedge clk) begin
    if (!done) begin
      check(state == m_st, tag_of(m_st), "state", state, m_st);
      check({sys_en, pwr_en, core_rst_n} == {m_sys, m_pwr, m_crn}, tag_of(m_st),
            "enables", {sys_en, pwr_en, core_rst_n}, {m_sys, m_pwr, m_crn});
      check(!(pwr_en && !sys_en) && !(core_rst_n && !pwr_en), "R10", "order",
            {sys_en, pwr_en, core_rst_n}, {m_sys, m_pwr, m_crn});
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(1);
      tick = 1'b0; step(3);
    end
  endtask

  task automatic expect_st(logic [2:0] s, string req);
    check(state == s, req, "directed state", state, s);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; tick = 0; ext_n = 0; batt_n = 0; rail_n = 0;
    step(4);
    // R1: reset state
    check({sys_en, pwr_en, core_rst_n, state} == 6'd0, "R1", "reset outputs",
          {sys_en, pwr_en, core_rst_n, state}, 0);
    rst_n = 1; batt_n = 1;
    step(4);
    // R2: release seen on third edge only
    ext_n = 1;
    step(2); expect_st(S_IDLE, "R2");
    step(1); expect_st(S_WSYS, "R3");
    // R4 / R5 timing
    tick_n(SYS_D - 1); expect_st(S_WSYS, "R4");
    tick_n(1);         expect_st(S_WPWR, "R4");
    check(sys_en && !pwr_en, "R4", "sys_en only", {sys_en, pwr_en}, 2);
    tick_n(PWR_D);     expect_st(S_WRAIL, "R5");
    check(sys_en && pwr_en, "R5", "both enables", {sys_en, pwr_en}, 3);
    // R6: rail low and toggling inside the window is ignored
    for (int i = 0; i < RAIL_D - 1; i++) begin
      rail_n = i[0];
      tick_n(1);
    end
    expect_st(S_WRAIL, "R6");
    rail_n = 1; step(3);
    tick_n(1); expect_st(S_RUN, "R7");
    check(core_rst_n == 1'b1, "R7", "core release", core_rst_n, 1);
    // R9: external reset abort
    ext_n = 0; step(2); expect_st(S_RUN, "R2");
    step(1); expect_st(S_IDLE, "R9");
    check({sys_en, pwr_en, core_rst_n} == 3'd0, "R9", "outputs low", {sys_en, pwr_en, core_rst_n}, 0);
    // R8: fault path
    ext_n = 1; step(3); expect_st(S_WSYS, "R3");
    tick_n(SYS_D); tick_n(PWR_D);
    rail_n = 0; step(3);
    tick_n(RAIL_D); expect_st(S_FAULT, "R8");
    check({sys_en, pwr_en, core_rst_n} == 3'd0, "R8", "fault outputs", {sys_en, pwr_en, core_rst_n}, 0);
    rail_n = 1; tick_n(10); expect_st(S_FAULT, "R8");
    ext_n = 0; step(3); expect_st(S_IDLE, "R8");
    ext_n = 1; step(3); expect_st(S_WSYS, "R3");
    // R9: battery fault abort, R3: no start when battery returns later
    tick_n(SYS_D); expect_st(S_WPWR, "R4");
    batt_n = 0; step(3); expect_st(S_IDLE, "R9");
    batt_n = 1; step(3); tick_n(SYS_D + 2); expect_st(S_IDLE, "R3");
    ext_n = 0; batt_n = 0; step(3);
    ext_n = 1; step(3); batt_n = 1; step(5);
    tick_n(20); expect_st(S_IDLE, "R3");
    // R10: tick on the entry edge is not counted
    ext_n = 0; step(3); ext_n = 1; step(2);
    tick = 1; step(1); tick = 0; step(3);
    expect_st(S_WSYS, "R10");
    tick_n(SYS_D - 1); expect_st(S_WSYS, "R10");
    tick_n(1); expect_st(S_WPWR, "R10");
    // constrained random phase, checked by the model each cycle
    for (int c = 0; c < 6000; c++) begin
      tick = (($urandom % 4) == 0);
      if (!ext_n) ext_n = (($urandom % 6) == 0);
      else if (($urandom % 300) == 0) ext_n = 0;
      if (!batt_n) batt_n = (($urandom % 4) == 0);
      else if (($urandom % 500) == 0) batt_n = 0;
      if (($urandom % 12) == 0) rail_n = (($urandom % 3) != 0);
      step(1);
    end
    done = 1;
    summary();
    $finish;
  end

endmodule